// File: doc/BRIEF.md
# Chained Two-Stage ALU Execute Unit

This block is the execute stage of a small 16-bit processor, with its own register file of eight 16-bit registers. Each cycle it takes one already decoded instruction as a set of separate field inputs. All of the fields come from one 24-bit instruction word, but the bit layout of that word is handled outside this block. The block computes a result and, when the write enable is high, writes that result back to a destination register on the next rising clock edge.

The datapath has two ALU stages in series. The inner stage works on a register and on either a second register or a zero-extended 3-bit immediate. Its result can replace either operand of the outer stage, or both operands. Each outer operand can instead be a register or a zero-extended 8-bit immediate. A load-immediate instruction skips both stages and writes a full 16-bit constant. The outer stage sets a zero flag. Add and subtract also set a carry flag. Both flags are registered and change only when an ALU instruction is written back.

A separate observation read port lets the surrounding logic read any register without using the instruction path.

Top module: `chalu_exec`

## Requirements
- R1: An active-low asynchronous reset clears all eight registers and both flags to zero. The reset release is synchronised to the clock.
- R2: When `ldi_i` and `we_i` are both high, `imm16_i` is written to register `dst_i` on the clock edge and both flags keep their values.
- R3: Outer operation codes are: 0 add, 1 subtract (A-B), 2 NAND, 3 NOR, 4 NOT of A, 5 left shift of A by B[3:0] with the bits shifted out discarded, 6 and 7 pass A. The outer result appears combinationally on `result_o`.
- R4: Each outer operand has its own 2-bit source select: 0 register, 1 `imm8_i` zero-extended to 16 bits, 2 the inner result, 3 register.
- R5: The inner stage uses the same operation codes. Its first operand is register `in_x_i`. Its second operand is register `in_y_i`, or `imm3_i` zero-extended when `in_y_imm_i` is 1. One inner result can feed both outer operands in the same cycle.
- R6: Write-back happens on the rising edge when `we_i` is high. Register reads in that same cycle, including reads of the destination register, return the value from before the write.
- R7: When `we_i` is low, no register and no flag changes, whatever the other inputs are.
- R8: After an ALU write-back, `zero_o` is 1 exactly when the outer result was 0x0000.
- R9: After an ALU write-back, `carry_o` holds the add carry-out for add, or 1 when A < B unsigned for subtract. For every other operation it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write-back enable for this instruction |
| ldi_i | input | 1 | Load-immediate instruction |
| dst_i | input | 3 | Destination register |
| op_i | input | 3 | Outer operation code |
| a_src_i | input | 2 | Source select for outer operand A |
| b_src_i | input | 2 | Source select for outer operand B |
| a_reg_i | input | 3 | Register for operand A |
| b_reg_i | input | 3 | Register for operand B |
| imm8_i | input | 8 | Outer short immediate |
| in_op_i | input | 3 | Inner operation code |
| in_x_i | input | 3 | Inner first operand register |
| in_y_i | input | 3 | Inner second operand register |
| in_y_imm_i | input | 1 | Inner second operand is the 3-bit immediate |
| imm3_i | input | 3 | Inner immediate |
| imm16_i | input | 16 | Load-immediate constant |
| obs_sel_i | input | 3 | Observation read address |
| result_o | output | 16 | Combinational outer result |
| obs_data_o | output | 16 | Observation read data |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry flag |

## Verification
The main function is driven by a table of instructions over preloaded register values. The table is ordered so that register-only, immediate-only and inner-stage operand patterns can each be told apart. Inner results are placed in the A position, in the B position and in both positions, so a wrong routing of the inner result shows up as a wrong sum. The patterns include an add that overflows, a subtract with a borrow, a subtract of equal values, shifts whose amount has bits above bit 3, and immediates that would give different results if they were sign-extended. These also show whether the carry flag is held or overwritten by the logical operations that follow an add or subtract. Directed cases then cover a read and write of the same register in one cycle, writes held off by a low enable, flags kept across a load-immediate, and a reset asserted in the middle of a run.

// File: rtl/chalu_pkg.sv
package chalu_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_REG = 8;
  localparam int unsigned IMM_L_W = 8;
  localparam int unsigned IMM_S_W = 3;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_NAND  = 3'd2,
    OP_NOR   = 3'd3,
    OP_NOT   = 3'd4,
    OP_SHL   = 3'd5,
    OP_PASS  = 3'd6,
    OP_PASS2 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_IMM   = 2'd1,
    SRC_INNER = 2'd2,
    SRC_RSV   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/chalu_alu.sv
module chalu_alu
  import chalu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         cout_o,
  output logic         cupd_o
);
  localparam int unsigned SHW = $clog2(W);

  logic [W:0]     sum;
  logic [SHW-1:0] shamt;

  assign sum   = {1'b0, a_i} + {1'b0, b_i};
  assign shamt = b_i[SHW-1:0];

  always_comb begin
    y_o    = a_i;
    cout_o = 1'b0;
    cupd_o = 1'b0;
    unique case (alu_op_e'(op_i))
      OP_ADD: begin
        y_o    = sum[W-1:0];
        cout_o = sum[W];
        cupd_o = 1'b1;
      end
      OP_SUB: begin
        y_o    = a_i - b_i;
        cout_o = (a_i < b_i);
        cupd_o = 1'b1;
      end
      OP_NAND:  y_o = ~(a_i & b_i);
      OP_NOR:   y_o = ~(a_i | b_i);
      OP_NOT:   y_o = ~a_i;
      OP_SHL:   y_o = a_i << shamt;
      OP_PASS,
      OP_PASS2: y_o = a_i;
      default:  y_o = a_i;
    endcase
  end
endmodule

// File: rtl/chalu_opmux.sv
module chalu_opmux
  import chalu_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned IMM_W = IMM_L_W
) (
  input  logic [1:0]       sel_i,
  input  logic [W-1:0]     reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     inner_i,
  output logic [W-1:0]     val_o
);
  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_IMM:   val_o = {{(W-IMM_W){1'b0}}, imm_i};
      SRC_INNER: val_o = inner_i;
      default:   val_o = reg_i;
    endcase
  end
endmodule

// File: rtl/chalu_regfile.sv
module chalu_regfile
  import chalu_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter int unsigned NREG = NUM_REG,
  parameter int unsigned NRD  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic [$clog2(NREG)-1:0] raddr_i [NRD],
  output logic [W-1:0]           rdata_o [NRD],
  output logic [NREG*W-1:0]      q_flat_o
);
  logic [W-1:0] regs_q [NREG];
  logic [W-1:0] regs_d [NREG];

  always_comb begin
    for (int i = 0; i < int'(NREG); i++) begin
      regs_d[i] = regs_q[i];
    end
    if (we_i) begin
      regs_d[waddr_i] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) begin
        regs_q[i] <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < int'(NREG); i++) begin
        regs_q[i] <= regs_d[i];
      end
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end

  for (genvar r = 0; r < int'(NREG); r++) begin : g_flat
    assign q_flat_o[r*W +: W] = regs_q[r];
  end
endmodule

// File: rtl/chalu_exec.sv
module chalu_exec
  import chalu_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned NREG  = NUM_REG,
  parameter int unsigned IMM_L = IMM_L_W,
  parameter int unsigned IMM_S = IMM_S_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     ldi_i,
  input  logic [$clog2(NREG)-1:0]  dst_i,
  input  logic [2:0]               op_i,
  input  logic [1:0]               a_src_i,
  input  logic [1:0]               b_src_i,
  input  logic [$clog2(NREG)-1:0]  a_reg_i,
  input  logic [$clog2(NREG)-1:0]  b_reg_i,
  input  logic [IMM_L-1:0]         imm8_i,
  input  logic [2:0]               in_op_i,
  input  logic [$clog2(NREG)-1:0]  in_x_i,
  input  logic [$clog2(NREG)-1:0]  in_y_i,
  input  logic                     in_y_imm_i,
  input  logic [IMM_S-1:0]         imm3_i,
  input  logic [W-1:0]             imm16_i,
  input  logic [$clog2(NREG)-1:0]  obs_sel_i,
  output logic [W-1:0]             result_o,
  output logic [W-1:0]             obs_data_o,
  output logic                     zero_o,
  output logic                     carry_o
);
  localparam int unsigned AW   = $clog2(NREG);
  localparam int unsigned NRD  = 5;
  localparam int unsigned P_A  = 0;
  localparam int unsigned P_B  = 1;
  localparam int unsigned P_X  = 2;
  localparam int unsigned P_Y  = 3;
  localparam int unsigned P_OB = 4;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // register file
  logic [AW-1:0]     raddr [NRD];
  logic [W-1:0]      rdata [NRD];
  logic [NREG*W-1:0] rf_flat;
  logic [W-1:0]      wb_data;

  assign raddr[P_A]  = a_reg_i;
  assign raddr[P_B]  = b_reg_i;
  assign raddr[P_X]  = in_x_i;
  assign raddr[P_Y]  = in_y_i;
  assign raddr[P_OB] = obs_sel_i;

  chalu_regfile #(.W(W), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_q),
    .we_i     (we_i),
    .waddr_i  (dst_i),
    .wdata_i  (wb_data),
    .raddr_i  (raddr),
    .rdata_o  (rdata),
    .q_flat_o (rf_flat)
  );

  // inner stage
  logic [W-1:0] in_y_val, in_res;
  logic         in_cout, in_cupd;

  assign in_y_val = in_y_imm_i ? {{(W-IMM_S){1'b0}}, imm3_i} : rdata[P_Y];

  chalu_alu #(.W(W)) u_inner (
    .op_i   (in_op_i),
    .a_i    (rdata[P_X]),
    .b_i    (in_y_val),
    .y_o    (in_res),
    .cout_o (in_cout),
    .cupd_o (in_cupd)
  );

  // outer operand selection
  logic [1:0]   src_sel [2];
  logic [W-1:0] src_reg [2];
  logic [W-1:0] opnd    [2];

  assign src_sel[0] = a_src_i;
  assign src_sel[1] = b_src_i;
  assign src_reg[0] = rdata[P_A];
  assign src_reg[1] = rdata[P_B];

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    chalu_opmux #(.W(W), .IMM_W(IMM_L)) u_mux (
      .sel_i   (src_sel[k]),
      .reg_i   (src_reg[k]),
      .imm_i   (imm8_i),
      .inner_i (in_res),
      .val_o   (opnd[k])
    );
  end

  // outer stage
  logic [W-1:0] out_res;
  logic         out_cout, out_cupd;

  chalu_alu #(.W(W)) u_outer (
    .op_i   (op_i),
    .a_i    (opnd[0]),
    .b_i    (opnd[1]),
    .y_o    (out_res),
    .cout_o (out_cout),
    .cupd_o (out_cupd)
  );

  assign result_o   = out_res;
  assign wb_data    = ldi_i ? imm16_i : out_res;
  assign obs_data_o = rdata[P_OB];

  // flags: next-state and register processes
  logic alu_wb, flag_en;
  logic zero_d, carry_d, zero_q, carry_q;

  assign alu_wb  = we_i & ~ldi_i;
  assign flag_en = alu_wb;

  always_comb begin
    zero_d  = (out_res == '0);
    carry_d = out_cupd ? out_cout : carry_q;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (flag_en) begin
      zero_q  <= zero_d;
      carry_q <= carry_d;
    end
  end

  assign zero_o  = zero_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/chalu_exec_chk.sv
module chalu_exec_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned NREG = 8
) (
  input logic                    clk_i,
  input logic                    rst_q,
  input logic                    we_i,
  input logic                    ldi_i,
  input logic [$clog2(NREG)-1:0] dst_i,
  input logic [2:0]              op_i,
  input logic [W-1:0]            imm16_i,
  input logic [W-1:0]            result_o,
  input logic                    zero_o,
  input logic                    carry_o,
  input logic [NREG*W-1:0]       rf_flat
);
  // R2: load-immediate lands in the destination and leaves flags alone
  a_r2_ldi_write: assert property (@(posedge clk_i) disable iff (!rst_q)
    (we_i && ldi_i) |=> (rf_flat[$past(dst_i)*W +: W] == $past(imm16_i))
                        && $stable(zero_o) && $stable(carry_o));

  // R7: no enable means no state change
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_q)
    !we_i |=> $stable(rf_flat) && $stable(zero_o) && $stable(carry_o));

  // R6: ALU write-back stores the outer result in the destination
  a_r6_writeback: assert property (@(posedge clk_i) disable iff (!rst_q)
    (we_i && !ldi_i) |=> rf_flat[$past(dst_i)*W +: W] == $past(result_o));

  // R8: zero flag follows the written outer result
  a_r8_zero: assert property (@(posedge clk_i) disable iff (!rst_q)
    (we_i && !ldi_i) |=> zero_o == ($past(result_o) == '0));

  // R9: carry kept for operations other than add and subtract
  a_r9_carry_keep: assert property (@(posedge clk_i) disable iff (!rst_q)
    (we_i && !ldi_i && op_i > 3'd1) |=> $stable(carry_o));
endmodule

bind chalu_exec chalu_exec_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk_i    (clk_i),
  .rst_q    (rst_q),
  .we_i     (we_i),
  .ldi_i    (ldi_i),
  .dst_i    (dst_i),
  .op_i     (op_i),
  .imm16_i  (imm16_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .carry_o  (carry_o),
  .rf_flat  (rf_flat)
);

// File: tb/test_chalu_exec.sv
module test_chalu_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        we_i, ldi_i, in_y_imm_i;
  logic [2:0]  dst_i, op_i, a_reg_i, b_reg_i, in_op_i, in_x_i, in_y_i, imm3_i, obs_sel_i;
  logic [1:0]  a_src_i, b_src_i;
  logic [7:0]  imm8_i;
  logic [15:0] imm16_i, result_o, obs_data_o;
  logic        zero_o, carry_o;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  chalu_exec i_chalu_exec (.*);

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ma;
    logic [1:0]  mb;
    logic [2:0]  ra;
    logic [2:0]  rb;
    logic [7:0]  imm8;
    logic [2:0]  iop;
    logic [2:0]  ix;
    logic [2:0]  iy;
    logic        isel;
    logic [2:0]  imm3;
    logic [15:0] res;
    logic        c;
    logic        z;
  } vec_t;

  // preload: r1=1234 r2=00FF r3=FFFF r4=8001 r5=0003 r0=0
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0,2'd0,2'd0,3'd1,3'd2,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'h1333,1'b0,1'b0},
    '{3'd0,2'd0,2'd1,3'd3,3'd0,8'h01,3'd0,3'd0,3'd0,1'b0,3'd0,16'h0000,1'b1,1'b1},
    '{3'd1,2'd0,2'd0,3'd2,3'd1,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'hEECB,1'b1,1'b0},
    '{3'd1,2'd1,2'd0,3'd0,3'd5,8'h10,3'd0,3'd0,3'd0,1'b0,3'd0,16'h000D,1'b0,1'b0},
    '{3'd2,2'd0,2'd0,3'd1,3'd3,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'hEDCB,1'b0,1'b0},
    '{3'd3,2'd0,2'd0,3'd0,3'd0,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'hFFFF,1'b0,1'b0},
    '{3'd4,2'd0,2'd0,3'd3,3'd0,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'h0000,1'b0,1'b1},
    '{3'd5,2'd0,2'd1,3'd5,3'd0,8'h04,3'd0,3'd0,3'd0,1'b0,3'd0,16'h0030,1'b0,1'b0},
    '{3'd5,2'd0,2'd1,3'd1,3'd0,8'h14,3'd0,3'd0,3'd0,1'b0,3'd0,16'h2340,1'b0,1'b0},
    '{3'd0,2'd2,2'd0,3'd0,3'd2,8'h00,3'd0,3'd1,3'd0,1'b1,3'd7,16'h133A,1'b0,1'b0},
    '{3'd1,2'd0,2'd2,3'd1,3'd0,8'h00,3'd5,3'd5,3'd0,1'b1,3'd2,16'h1228,1'b0,1'b0},
    '{3'd3,2'd2,2'd0,3'd0,3'd0,8'h00,3'd1,3'd4,3'd5,1'b0,3'd0,16'h8001,1'b0,1'b0},
    '{3'd0,2'd2,2'd1,3'd0,3'd0,8'hFF,3'd4,3'd2,3'd0,1'b0,3'd0,16'hFFFF,1'b0,1'b0},
    '{3'd0,2'd0,2'd0,3'd4,3'd4,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'h0002,1'b1,1'b0},
    '{3'd2,2'd0,2'd0,3'd3,3'd3,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'h0000,1'b1,1'b1},
    '{3'd1,2'd0,2'd0,3'd5,3'd5,8'h00,3'd0,3'd0,3'd0,1'b0,3'd0,16'h0000,1'b0,1'b1},
    '{3'd0,2'd2,2'd2,3'd0,3'd0,8'h00,3'd0,3'd5,3'd0,1'b1,3'd1,16'h0008,1'b0,1'b0},
    '{3'd5,2'd0,2'd1,3'd5,3'd0,8'h0F,3'd0,3'd0,3'd0,1'b0,3'd0,16'h8000,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    we_i = 0; ldi_i = 0; dst_i = 0; op_i = 0; a_src_i = 0; b_src_i = 0;
    a_reg_i = 0; b_reg_i = 0; imm8_i = 0; in_op_i = 0; in_x_i = 0; in_y_i = 0;
    in_y_imm_i = 0; imm3_i = 0; imm16_i = 0;
  endtask

  task automatic ldi(input logic [2:0] d, input logic [15:0] v);
    @(negedge clk_i);
    idle_inputs();
    we_i = 1; ldi_i = 1; dst_i = d; imm16_i = v;
    @(negedge clk_i);
    we_i = 0; ldi_i = 0;
  endtask

  task automatic rd(input logic [2:0] r, output logic [15:0] v);
    obs_sel_i = r;
    #1 v = obs_data_o;
  endtask

  initial begin
    logic [15:0] v;
    string tag;
    idle_inputs();
    obs_sel_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), v);
      chk("R1 reg after reset", v, 16'h0);
    end
    chk("R1 zero after reset", {15'b0, zero_o}, 16'h0);
    chk("R1 carry after reset", {15'b0, carry_o}, 16'h0);

    // R2: preload registers via load-immediate
    ldi(3'd1, 16'h1234);
    ldi(3'd2, 16'h00FF);
    ldi(3'd3, 16'hFFFF);
    ldi(3'd4, 16'h8001);
    ldi(3'd5, 16'h0003);
    rd(3'd1, v); chk("R2 ldi r1", v, 16'h1234);
    rd(3'd4, v); chk("R2 ldi r4", v, 16'h8001);
    chk("R2 flags after ldi", {14'b0, zero_o, carry_o}, 16'h0);

    // table of ALU instructions, destination r7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      idle_inputs();
      we_i = 1; dst_i = 3'd7;
      op_i = VECS[i].op; a_src_i = VECS[i].ma; b_src_i = VECS[i].mb;
      a_reg_i = VECS[i].ra; b_reg_i = VECS[i].rb; imm8_i = VECS[i].imm8;
      in_op_i = VECS[i].iop; in_x_i = VECS[i].ix; in_y_i = VECS[i].iy;
      in_y_imm_i = VECS[i].isel; imm3_i = VECS[i].imm3;
      #1;
      if (VECS[i].ma == 2'd2 || VECS[i].mb == 2'd2) tag = "R5 inner result";
      else if (VECS[i].ma == 2'd1 || VECS[i].mb == 2'd1) tag = "R4 imm8 operand";
      else tag = "R3 outer op";
      chk(tag, result_o, VECS[i].res);
      @(negedge clk_i);
      we_i = 0;
      rd(3'd7, v);
      chk("R6 writeback r7", v, VECS[i].res);
      chk("R8 zero flag", {15'b0, zero_o}, {15'b0, VECS[i].z});
      chk("R9 carry flag", {15'b0, carry_o}, {15'b0, VECS[i].c});
    end

    // R6: read of destination in the write cycle returns the old value
    @(negedge clk_i);
    idle_inputs();
    we_i = 1; dst_i = 3'd1; op_i = 3'd0; a_reg_i = 3'd1; b_src_i = 2'd1; imm8_i = 8'h01;
    rd(3'd1, v);
    chk("R6 old value before edge", v, 16'h1234);
    chk("R6 result uses old value", result_o, 16'h1235);
    @(negedge clk_i);
    we_i = 0;
    rd(3'd1, v);
    chk("R6 new value after edge", v, 16'h1235);

    // set both flags: r6 = FFFF + 1
    @(negedge clk_i);
    idle_inputs();
    we_i = 1; dst_i = 3'd6; op_i = 3'd0; a_reg_i = 3'd3; b_src_i = 2'd1; imm8_i = 8'h01;
    @(negedge clk_i);
    we_i = 0;
    chk("R9 carry set by add", {14'b0, zero_o, carry_o}, 16'h3);

    // R7: enable low, ALU and load-immediate stimulus ignored
    idle_inputs();
    dst_i = 3'd6; op_i = 3'd0; a_reg_i = 3'd1; b_reg_i = 3'd2;
    @(negedge clk_i);
    ldi_i = 1; imm16_i = 16'hBEEF;
    @(negedge clk_i);
    ldi_i = 0;
    rd(3'd6, v);
    chk("R7 reg unchanged with we low", v, 16'h0000);
    chk("R7 flags unchanged with we low", {14'b0, zero_o, carry_o}, 16'h3);

    // R2: load-immediate keeps flags
    ldi(3'd6, 16'hBEEF);
    rd(3'd6, v);
    chk("R2 ldi r6", v, 16'hBEEF);
    chk("R2 flags kept by ldi", {14'b0, zero_o, carry_o}, 16'h3);

    // R9: NAND clears zero, keeps carry
    @(negedge clk_i);
    idle_inputs();
    we_i = 1; dst_i = 3'd6; op_i = 3'd2; a_reg_i = 3'd1; b_reg_i = 3'd1;
    @(negedge clk_i);
    we_i = 0;
    rd(3'd6, v);
    chk("R3 nand same reg", v, 16'hEDCA);
    chk("R9 carry kept by nand", {14'b0, zero_o, carry_o}, 16'h1);

    // R1: reset in mid-run
    @(negedge clk_i);
    rst_ni = 0;
    rd(3'd1, v);
    chk("R1 reg cleared by reset", v, 16'h0);
    chk("R1 flags cleared by reset", {14'b0, zero_o, carry_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    rd(3'd6, v);
    chk("R1 reg still zero after release", v, 16'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule